// File: doc/BRIEF.md
# Edge-Gated Phase Difference Meter

This block measures the phase lag of a response square wave against a reference square wave of the same frequency. Both are taken from comparators that shape two analog signals at their zero crossings. A rising edge of the reference opens a measurement and starts a free-running cycle counter. The rising edge of the response fixes the interval count M. The next rising edge of the reference fixes the period count P. Both counts are in cycles of the block clock.

A sequential restoring divider then forms floor(360 × M / P). This gives a phase in whole degrees from 0 to 359, at any input frequency the counters can hold. Each result appears on the outputs together with a one-cycle done strobe and stays there until the next strobe. A missing response edge is reported as a timeout. A count that reaches the top of its range is reported as an overflow. Both inputs are asynchronous and go through synchronisers of equal depth, so the delay cancels out of M.

The controller has five states:
- IDLE waits for a reference rise. It goes to INTERVAL, or straight to PERIOD when the response rises in the same cycle.
- INTERVAL counts until one of three events, checked in this order. Saturation goes to REPORT with overflow. A reference rise goes to REPORT with timeout. A response rise goes to PERIOD.
- PERIOD counts until saturation, which goes to REPORT with overflow, or a reference rise, which goes to DIVIDE.
- DIVIDE waits for the divider to finish and then goes to REPORT.
- REPORT publishes the result and returns to IDLE.

A new measurement therefore starts at the first reference rise after REPORT.

Top module: `phase_meter`

## Requirements
- R1: The interval count is the number of clock cycles from a reference rising edge to the next response rising edge, with both edges seen after equal synchronisation.
- R2: The period count is the number of clock cycles between the reference rising edge that opened the measurement and the next reference rising edge.
- R3: The phase output is floor(360 × interval / period). For any valid result it lies in 0 to 359.
- R4: A response rise in the same cycle as the opening reference rise gives an interval count of 0 and a phase of 0.
- R5: If the reference rises again before any response rise, the result carries timed_out=1, interval 0, phase 0 and the measured period.
- R6: When a count reaches 2^CNT_W−1, the measurement is aborted with overflowed=1, timed_out=0 and phase 0. The period field is all ones. The interval field is all ones if the response had not yet risen, and otherwise holds the captured interval.
- R7: meas_done is high for exactly one cycle per result. All result outputs hold their value between strobes.
- R8: While reset is asserted, and after it is released until the first result, all outputs are zero.
- R9: With a 5000-cycle period (20 kHz at 100 MHz), one interval count is worth 0.072°. The phase is truncated: 1 count gives 0, 14 counts give 1, 2500 give 180 and 4999 give 359.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low reset |
| ref_in | input | 1 | Shaped reference square wave, asynchronous |
| rsp_in | input | 1 | Shaped response square wave, asynchronous |
| meas_done | output | 1 | One-cycle strobe marking a new result |
| timed_out | output | 1 | Result had no response edge within one period |
| overflowed | output | 1 | Result aborted by a saturated count |
| interval_cnt | output | CNT_W | Reference-to-response count M |
| period_cnt | output | CNT_W | Reference period count P |
| phase_deg | output | 9 | Phase lag in whole degrees |

## Verification
The assertions assume that reset is low from time zero. They also assume that the two inputs are square waves of one shared period, with the response rising at most once per period. The relations they check between the flags and the counts depend on that assumption. The stimulus makes every edge land on a clock boundary, so that M and P are exact integers. It holds the response low until its first scheduled rise, so that no spurious rise occurs together with the first reference edge. It also applies reset between patterns, so that no measurement straddles two different frequencies.

// File: rtl/phase_meter_pkg.sv
package phase_meter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INTERVAL,
        ST_PERIOD,
        ST_DIVIDE,
        ST_REPORT
    } meas_state_t;

    localparam int DEG_W     = 9;
    localparam int FULL_TURN = 360;

endpackage

// File: rtl/phase_meter_sync.sv
module phase_meter_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i <= STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/phase_meter_cnt.sv
module phase_meter_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         at_max
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= W'(1);
        end else if (en && !at_max) begin
            cnt <= cnt + W'(1);
        end
    end

    assign at_max = &cnt;
endmodule

// File: rtl/phase_meter_div.sv
module phase_meter_div #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 24,
    parameter int Q_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  qn;
    logic [DEN_W-1:0]  rem;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] steps;
    logic              busy;
    logic [DEN_W:0]    shifted;
    logic [DEN_W:0]    trial;

    always_comb begin
        shifted = {rem, qn[NUM_W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qn    <= '0;
            rem   <= '0;
            den_q <= '0;
            steps <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                qn    <= num;
                rem   <= '0;
                den_q <= den;
                steps <= STEP_W'(NUM_W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (!trial[DEN_W]) begin
                    rem <= trial[DEN_W-1:0];
                    qn  <= {qn[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= shifted[DEN_W-1:0];
                    qn  <= {qn[NUM_W-2:0], 1'b0};
                end
                steps <= steps - STEP_W'(1);
                if (steps == STEP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = qn[Q_W-1:0];
endmodule

// File: rtl/phase_meter.sv
module phase_meter
    import phase_meter_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             rsp_in,
    output logic             meas_done,
    output logic             timed_out,
    output logic             overflowed,
    output logic [CNT_W-1:0] interval_cnt,
    output logic [CNT_W-1:0] period_cnt,
    output logic [DEG_W-1:0] phase_deg
);
    localparam int               NUM_W   = CNT_W + DEG_W;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    meas_state_t state, nstate;

    logic             ref_rise, rsp_rise;
    logic [CNT_W-1:0] cnt;
    logic             cnt_top;
    logic             cnt_load, cnt_run;
    logic [CNT_W-1:0] m_q, p_q;
    logic             to_q, ov_q;
    logic             div_start, div_done;
    logic [DEG_W-1:0] div_quo;
    logic [NUM_W-1:0] scaled;

    phase_meter_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise(ref_rise)
    );

    phase_meter_sync #(.STAGES(SYNC_STAGES)) u_rsp_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rsp_in), .rise(rsp_rise)
    );

    phase_meter_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .en(cnt_run),
        .cnt(cnt), .at_max(cnt_top)
    );

    assign scaled = NUM_W'(m_q) * NUM_W'(FULL_TURN);

    phase_meter_div #(.NUM_W(NUM_W), .DEN_W(CNT_W), .Q_W(DEG_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(scaled),
        .den(cnt), .done(div_done), .quo(div_quo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions and counter control
    always_comb begin
        nstate    = state;
        cnt_load  = 1'b0;
        cnt_run   = 1'b0;
        div_start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_rise) begin
                    cnt_load = 1'b1;
                    nstate   = rsp_rise ? ST_PERIOD : ST_INTERVAL;
                end
            end
            ST_INTERVAL: begin
                cnt_run = 1'b1;
                if (cnt_top || ref_rise) nstate = ST_REPORT;
                else if (rsp_rise)       nstate = ST_PERIOD;
            end
            ST_PERIOD: begin
                cnt_run = 1'b1;
                if (cnt_top) begin
                    nstate = ST_REPORT;
                end else if (ref_rise) begin
                    div_start = 1'b1;
                    nstate    = ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (div_done) nstate = ST_REPORT;
            end
            ST_REPORT: nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    // captured counts and published outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q          <= '0;
            p_q          <= '0;
            to_q         <= 1'b0;
            ov_q         <= 1'b0;
            meas_done    <= 1'b0;
            timed_out    <= 1'b0;
            overflowed   <= 1'b0;
            interval_cnt <= '0;
            period_cnt   <= '0;
            phase_deg    <= '0;
        end else begin
            meas_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ref_rise) begin
                        m_q  <= '0;
                        p_q  <= '0;
                        to_q <= 1'b0;
                        ov_q <= 1'b0;
                    end
                end
                ST_INTERVAL: begin
                    if (cnt_top) begin
                        m_q  <= CNT_TOP;
                        p_q  <= CNT_TOP;
                        ov_q <= 1'b1;
                    end else if (ref_rise) begin
                        m_q  <= '0;
                        p_q  <= cnt;
                        to_q <= 1'b1;
                    end else if (rsp_rise) begin
                        m_q <= cnt;
                    end
                end
                ST_PERIOD: begin
                    if (cnt_top) begin
                        p_q  <= CNT_TOP;
                        ov_q <= 1'b1;
                    end else if (ref_rise) begin
                        p_q <= cnt;
                    end
                end
                ST_DIVIDE: begin
                end
                ST_REPORT: begin
                    meas_done    <= 1'b1;
                    interval_cnt <= m_q;
                    period_cnt   <= p_q;
                    timed_out    <= to_q;
                    overflowed   <= ov_q;
                    phase_deg    <= (to_q || ov_q) ? '0 : div_quo;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/phase_meter_chk.sv
module phase_meter_chk
    import phase_meter_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_done,
    input logic             timed_out,
    input logic             overflowed,
    input logic [CNT_W-1:0] interval_cnt,
    input logic [CNT_W-1:0] period_cnt,
    input logic [DEG_W-1:0] phase_deg
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> !meas_done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_done |-> ($stable(phase_deg) && $stable(interval_cnt) &&
                        $stable(period_cnt) && $stable(timed_out) && $stable(overflowed)));

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> (phase_deg < DEG_W'(FULL_TURN)));

    // R1
    interval_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && !timed_out && !overflowed) |-> (interval_cnt < period_cnt));

    // R5
    timeout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && timed_out) |-> (interval_cnt == '0 && phase_deg == '0));

    // R6
    overflow_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && overflowed) |-> (&period_cnt && phase_deg == '0 && !timed_out));
endmodule

bind phase_meter phase_meter_chk #(.CNT_W(CNT_W)) u_phase_meter_chk (
    .clk(clk), .rst_n(rst_n), .meas_done(meas_done), .timed_out(timed_out),
    .overflowed(overflowed), .interval_cnt(interval_cnt),
    .period_cnt(period_cnt), .phase_deg(phase_deg)
);

// File: tb/phase_meter_test.sv
module phase_meter_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 14;
    localparam int TOP        = (1 << CW) - 1;
    localparam int WATCHDOG   = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_in = 1'b0;
    logic          rsp_in = 1'b0;
    logic          meas_done, timed_out, overflowed;
    logic [CW-1:0] interval_cnt, period_cnt;
    logic [8:0]    phase_deg;

    int nvec = 0;
    int nbad = 0;
    int done_seen = 0;
    bit finished = 0;

    // model of the held result and of the result expected for the running pattern
    int    held_int = 0, held_per = 0, held_ph = 0, held_to = 0, held_ov = 0;
    int    pat_int = 0, pat_per = 0, pat_ph = 0, pat_to = 0, pat_ov = 0;
    string pat_req = "R1";

    phase_meter #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rsp_in(rsp_in),
        .meas_done(meas_done), .timed_out(timed_out), .overflowed(overflowed),
        .interval_cnt(interval_cnt), .period_cnt(period_cnt), .phase_deg(phase_deg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        chk(req, "interval", int'(interval_cnt), held_int);
        chk(req, "period",   int'(period_cnt),   held_per);
        chk(req, "phase",    int'(phase_deg),    held_ph);
        chk(req, "timeout",  int'(timed_out),    held_to);
        chk(req, "overflow", int'(overflowed),   held_ov);
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (meas_done) begin
                done_seen++;
                held_int = pat_int; held_per = pat_per; held_ph = pat_ph;
                held_to  = pat_to;  held_ov  = pat_ov;
                compare_all(pat_req);
            end else begin
                compare_all("R7");
            end
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; ref_in = 1'b0; rsp_in = 1'b0;
        held_int = 0; held_per = 0; held_ph = 0; held_to = 0; held_ov = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8", "done in reset", int'(meas_done), 0);
        chk("R8", "phase in reset", int'(phase_deg), 0);
        chk("R8", "period in reset", int'(period_cnt), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    // dly < 0 keeps the response low for the whole pattern
    task automatic run_pattern(string req, int per, int dly, int nper);
        do_reset();
        pat_req = req;
        pat_to = 0; pat_ov = 0; pat_ph = 0;
        if (dly < 0) begin
            if (per >= TOP) begin pat_ov = 1; pat_int = TOP; pat_per = TOP; end
            else begin pat_to = 1; pat_int = 0; pat_per = per; end
        end else if (dly >= TOP) begin
            pat_ov = 1; pat_int = TOP; pat_per = TOP;
        end else if (per >= TOP) begin
            pat_ov = 1; pat_int = dly; pat_per = TOP;
        end else begin
            pat_int = dly; pat_per = per; pat_ph = (360 * dly) / per;
        end
        done_seen = 0;
        for (int p = 0; p < nper; p++) begin
            for (int i = 0; i < per; i++) begin
                @(posedge clk); #1;
                ref_in = (i < per / 2);
                rsp_in = (dly >= 0) && (p > 0 || i >= dly) &&
                         (((i - dly + per) % per) < per / 2);
            end
        end
        @(posedge clk); #1;
        ref_in = 1'b0; rsp_in = 1'b0;
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(req, "results reported", (done_seen >= 1) ? 1 : 0, 1);
    endtask

    initial begin
        run_pattern("R1", 100, 25, 2);      // R2 period, R3 90 deg
        run_pattern("R2", 360, 1, 2);
        run_pattern("R3", 20, 7, 3);        // 126 deg, divide spans periods
        run_pattern("R3", 100, 99, 2);      // 356 deg
        run_pattern("R4", 100, 0, 2);       // coincident edges
        run_pattern("R9", 5000, 1, 2);      // 0.072 deg -> 0
        run_pattern("R9", 5000, 14, 2);     // 1.008 deg -> 1
        run_pattern("R9", 5000, 2500, 2);   // 180
        run_pattern("R9", 5000, 4999, 2);   // 359.93 -> 359
        run_pattern("R5", 100, -1, 3);      // no response edge
        run_pattern("R6", 34000, 17000, 1); // interval saturates
        run_pattern("R6", 20000, 50, 1);    // period saturates
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule